// File: doc/BRIEF.md
# Velocity-Sensing Keyboard Matrix Scanner

This block reads a keyboard whose keys each carry two changeover contacts. One contact is closed at rest and opens early in the key's travel; the other closes near the bottom. The block grounds one select line per scan tick, so that a group of keys becomes visible on the pulled-up sense inputs. Each key owns two adjacent sense bits. The block times how many scan passes separate the upper contact opening from the lower contact closing. It turns that count into a 7-bit velocity, where a fast strike gives a large value, and queues note-on and note-off events behind a valid/ready handshake.

The select outputs and the sense inputs share one latch strobe, which is the scan tick. The sense word taken at a tick is therefore the answer to the select pattern that was already on the lines before that tick. The block credits that reading to that earlier column. In the same tick it moves the select lines on to the next column. After each tick, the keys of the captured column are updated one per clock, so at most one event is produced per clock.

Top module: `kbd_vel_scan`

## Requirements
- R1: While reset is held, and after it until the first scan tick, all select lines are high, no event is valid and the overflow flag is low.
- R2: Each scan tick drives exactly one select line low, stepping through columns 0, 1, …, NUM_SEL-1 and then back to 0. Column 0 is the first one after reset. Select lines change only at a tick.
- R3: Within a column, key k uses sense bit 2k for its upper contact and bit 2k+1 for its lower contact, and a low level means closed. Its key number is column×(NUM_SENSE/2)+k. The sense word sampled at a tick is credited to the column that was driven before that tick.
- R4: When an idle key's upper contact is seen open, its counter starts at 127.
- R5: On every later visit with the lower contact still open, the counter drops by VEL_STEP, which is 1 or 2. When the lower contact is seen closed, a note-on with the current counter value is emitted. So a lower-contact closure d passes after the opening gives velocity 127-(d-1)×VEL_STEP.
- R6: The counter never goes below 1, and a slow press reports velocity 1.
- R7: A sounding key whose upper contact is seen closed again emits a note-off with velocity 0 and returns to idle.
- R8: If the upper contact closes again before the lower contact, timing is abandoned, no event is emitted and the key returns to idle.
- R9: Events leave in the order they were produced. A valid event holds its fields unchanged until it is accepted with ready.
- R10: If the event queue (FIFO_DEPTH entries) is full when an event is produced, that new event is dropped and a sticky overflow flag is set, which only reset clears.
- R11: If both contacts are seen changed on the same first visit, a note-on with velocity 127 is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_tick | input | 1 | One-clock strobe that latches select outputs and samples sense inputs |
| sel_n | output | NUM_SEL | Column select lines, active low |
| sense_n | input | NUM_SENSE | Pulled-up contact sense lines, low = closed |
| ev_valid | output | 1 | Head event available |
| ev_ready | input | 1 | Consumer accepts head event |
| ev_key | output | 8 | Key number of head event |
| ev_on | output | 1 | 1 = note-on, 0 = note-off |
| ev_vel | output | 7 | Velocity, 0 for note-off |
| ev_overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
The assertions assume two things about the inputs. First, scan ticks arrive at least NUM_SENSE/2+1 clocks apart, so the walk over one column's keys finishes before the next capture. Second, the sense lines settle to the driven column before the next strobe. The bench pulses the tick every 16 clocks. It drives the sense lines combinationally from the select outputs and its own model of the contacts. It changes contacts only between whole scan passes, so every key is seen exactly once per pass. Ready is held high, except during the overflow test, where it is held low on purpose.

// File: rtl/kbd_scan_pkg.sv
// Shared widths, key state encoding and the event record of the scanner.
package kbd_scan_pkg;
    localparam int VEL_W = 7;
    localparam int KEY_W = 8;
    localparam logic [VEL_W-1:0] VEL_TOP = 7'd127;

    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_TIMING = 2'd1,
        KS_DOWN   = 2'd2
    } key_st_t;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             on;
        logic [VEL_W-1:0] vel;
    } note_ev_t;
endpackage

// File: rtl/kbd_col_seq.sv
// Column sequencer and read pipeline.
// On each scan_tick it captures the sense word, credits it to the column that
// was driven before the tick, and moves the select lines to the next column.
// It then walks the captured keys, one per clock.
// Assumes: ticks are at least KPS+1 clocks apart; NUM_SENSE is a power of two.
module kbd_col_seq #(
    parameter int NUM_SEL   = 12,
    parameter int NUM_SENSE = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scan_tick,
    input  logic [NUM_SENSE-1:0]     sense_n,
    output logic [NUM_SEL-1:0]       sel_n,
    output logic                     walk_valid,
    output logic [$clog2(NUM_SEL)-1:0] walk_col,
    output logic [$clog2(NUM_SENSE/2 > 1 ? NUM_SENSE/2 : 2)-1:0] walk_idx,
    output logic                     walk_brk_closed,
    output logic                     walk_mk_closed
);
    localparam int SEL_W = $clog2(NUM_SEL);
    localparam int KPS   = NUM_SENSE / 2;
    localparam int IDX_W = $clog2(KPS > 1 ? KPS : 2);
    localparam logic [NUM_SEL-1:0] ONE_HOT0 = {{(NUM_SEL-1){1'b0}}, 1'b1};

    logic [SEL_W-1:0]     col_q;
    logic                 col_valid_q;
    logic [NUM_SEL-1:0]   sel_q;
    logic [SEL_W-1:0]     col_next;
    logic [NUM_SENSE-1:0] cap_q;
    logic [SEL_W-1:0]     cap_col_q;
    logic                 busy_q;
    logic [IDX_W-1:0]     idx_q;

    // Next column to drive: column 0 after reset, then wrap around.
    always_comb begin
        if (!col_valid_q || col_q == SEL_W'(NUM_SEL - 1))
            col_next = '0;
        else
            col_next = col_q + SEL_W'(1);
    end

    // Select register: advances only on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q       <= '0;
            col_valid_q <= 1'b0;
            sel_q       <= '1;
        end else if (scan_tick) begin
            col_q       <= col_next;
            col_valid_q <= 1'b1;
            sel_q       <= ~(ONE_HOT0 << col_next);
        end
    end

    // Capture the reading for the column driven before the tick, then walk its keys.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= '1;
            cap_col_q <= '0;
            busy_q    <= 1'b0;
            idx_q     <= '0;
        end else if (scan_tick && col_valid_q) begin
            cap_q     <= sense_n;
            cap_col_q <= col_q;
            busy_q    <= 1'b1;
            idx_q     <= '0;
        end else if (busy_q) begin
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(KPS - 1))
                busy_q <= 1'b0;
        end
    end

    assign sel_n           = sel_q;
    assign walk_valid      = busy_q;
    assign walk_col        = cap_col_q;
    assign walk_idx        = idx_q;
    assign walk_brk_closed = ~cap_q[{idx_q, 1'b0}];
    assign walk_mk_closed  = ~cap_q[{idx_q, 1'b1}];

    // R2: select lines hold between ticks
    a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(sel_n));
    // R2: once started, exactly one line is low
    a_r2_one_low: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_q |-> $countones(~sel_n) == 1);
    // R2: each tick after the first moves the select pattern
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick && col_valid_q |=> sel_n != $past(sel_n));
    // R3: input assumption, the walk ends before the next capture
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick |-> !busy_q);
endmodule

// File: rtl/kbd_key_step.sv
// Next-state function of one key: idle, timing the contact race, sounding.
// Combinational; the caller holds the state and counter of every key.
// Assumes VEL_STEP is 1 or 2.
module kbd_key_step
    import kbd_scan_pkg::*;
#(
    parameter int VEL_STEP = 1
) (
    input  key_st_t          cur_st,
    input  logic [VEL_W-1:0] cur_cnt,
    input  logic             brk_closed,
    input  logic             mk_closed,
    output key_st_t          nxt_st,
    output logic [VEL_W-1:0] nxt_cnt,
    output logic             emit,
    output logic             emit_on,
    output logic [VEL_W-1:0] emit_vel
);
    localparam logic [VEL_W-1:0] STEP_V = VEL_W'(VEL_STEP);

    // Decide the key's transition and any event from one visit's reading.
    always_comb begin
        nxt_st   = cur_st;
        nxt_cnt  = cur_cnt;
        emit     = 1'b0;
        emit_on  = 1'b0;
        emit_vel = '0;
        unique case (cur_st)
            KS_IDLE: begin
                if (!brk_closed) begin
                    if (mk_closed) begin
                        nxt_st   = KS_DOWN;
                        emit     = 1'b1;
                        emit_on  = 1'b1;
                        emit_vel = VEL_TOP;
                    end else begin
                        nxt_st  = KS_TIMING;
                        nxt_cnt = VEL_TOP;
                    end
                end
            end
            KS_TIMING: begin
                if (brk_closed) begin
                    nxt_st = KS_IDLE;
                end else if (mk_closed) begin
                    nxt_st   = KS_DOWN;
                    emit     = 1'b1;
                    emit_on  = 1'b1;
                    emit_vel = cur_cnt;
                end else begin
                    nxt_cnt = (cur_cnt > STEP_V) ? cur_cnt - STEP_V : VEL_W'(1);
                end
            end
            KS_DOWN: begin
                if (brk_closed) begin
                    nxt_st = KS_IDLE;
                    emit   = 1'b1;
                end
            end
            default: nxt_st = KS_IDLE;
        endcase
    end
endmodule

// File: rtl/kbd_evt_fifo.sv
// Small event queue with valid/ready output and a sticky drop flag.
// A push that arrives while the queue is full is discarded.
// Assumes DEPTH is a power of two, at least 2.
module kbd_evt_fifo
    import kbd_scan_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  note_ev_t push_data,
    input  logic     pop_ready,
    output logic     out_valid,
    output note_ev_t out_data,
    output logic     overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    note_ev_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             accept;
    logic             pop;
    logic             ovf_q;

    assign full   = (count == CNT_W'(DEPTH));
    assign accept = push && !full;
    assign pop    = out_valid && pop_ready;

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (accept)
            mem[wr_ptr] <= push_data;
    end

    // Pointer, occupancy and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)    rd_ptr <= rd_ptr + PTR_W'(1);
            case ({accept, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
            if (push && full) ovf_q <= 1'b1;
        end
    end

    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign overflow  = ovf_q;

    // R9: a stalled head stays valid and unchanged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !pop_ready |=> out_valid && $stable(out_data));
    // R10: overflow is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R10: occupancy never exceeds depth
    a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/kbd_vel_scan.sv
// Velocity keyboard matrix scanner, top level.
// Holds the state and race counter of every key. It updates the keys of the
// captured column one per clock and queues the events they produce.
// Assumes NUM_SEL*NUM_SENSE/2 <= 256 and VEL_STEP in {1,2}.
module kbd_vel_scan
    import kbd_scan_pkg::*;
#(
    parameter int NUM_SEL    = 12,
    parameter int NUM_SENSE  = 16,
    parameter int VEL_STEP   = 1,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_tick,
    output logic [NUM_SEL-1:0]   sel_n,
    input  logic [NUM_SENSE-1:0] sense_n,
    output logic                 ev_valid,
    input  logic                 ev_ready,
    output logic [KEY_W-1:0]     ev_key,
    output logic                 ev_on,
    output logic [VEL_W-1:0]     ev_vel,
    output logic                 ev_overflow
);
    localparam int KPS      = NUM_SENSE / 2;
    localparam int NUM_KEYS = NUM_SEL * KPS;
    localparam int SEL_W    = $clog2(NUM_SEL);
    localparam int IDX_W    = $clog2(KPS > 1 ? KPS : 2);
    localparam int KIDX_W   = $clog2(NUM_KEYS);

    logic               walk_valid;
    logic [SEL_W-1:0]   walk_col;
    logic [IDX_W-1:0]   walk_idx;
    logic               brk_closed;
    logic               mk_closed;
    logic [KIDX_W-1:0]  key_idx;

    key_st_t            st_q  [NUM_KEYS];
    logic [VEL_W-1:0]   cnt_q [NUM_KEYS];
    key_st_t            cur_st;
    logic [VEL_W-1:0]   cur_cnt;
    key_st_t            nxt_st;
    logic [VEL_W-1:0]   nxt_cnt;
    logic               emit;
    logic               emit_on;
    logic [VEL_W-1:0]   emit_vel;
    note_ev_t           push_ev;
    note_ev_t           head_ev;
    logic               push;

    kbd_col_seq #(
        .NUM_SEL   (NUM_SEL),
        .NUM_SENSE (NUM_SENSE)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .scan_tick       (scan_tick),
        .sense_n         (sense_n),
        .sel_n           (sel_n),
        .walk_valid      (walk_valid),
        .walk_col        (walk_col),
        .walk_idx        (walk_idx),
        .walk_brk_closed (brk_closed),
        .walk_mk_closed  (mk_closed)
    );

    // Key number from column and position within the column.
    assign key_idx = KIDX_W'(walk_col) * KIDX_W'(KPS) + KIDX_W'(walk_idx);
    assign cur_st  = st_q[key_idx];
    assign cur_cnt = cnt_q[key_idx];

    kbd_key_step #(
        .VEL_STEP (VEL_STEP)
    ) u_step (
        .cur_st     (cur_st),
        .cur_cnt    (cur_cnt),
        .brk_closed (brk_closed),
        .mk_closed  (mk_closed),
        .nxt_st     (nxt_st),
        .nxt_cnt    (nxt_cnt),
        .emit       (emit),
        .emit_on    (emit_on),
        .emit_vel   (emit_vel)
    );

    // Per-key state and counter storage, written for the walked key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_KEYS; i++) begin
                st_q[i]  <= KS_IDLE;
                cnt_q[i] <= '0;
            end
        end else if (walk_valid) begin
            st_q[key_idx]  <= nxt_st;
            cnt_q[key_idx] <= nxt_cnt;
        end
    end

    assign push         = walk_valid && emit;
    assign push_ev.key  = KEY_W'(key_idx);
    assign push_ev.on   = emit_on;
    assign push_ev.vel  = emit_vel;

    kbd_evt_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_ev),
        .pop_ready (ev_ready),
        .out_valid (ev_valid),
        .out_data  (head_ev),
        .overflow  (ev_overflow)
    );

    assign ev_key = head_ev.key;
    assign ev_on  = head_ev.on;
    assign ev_vel = head_ev.vel;

    // R4: an upper-contact opening from idle loads the full count
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        walk_valid && cur_st == KS_IDLE && !brk_closed && !mk_closed
        |=> cnt_q[$past(key_idx)] == VEL_TOP);
    // R6: note-on velocity is never zero
    a_r6_vel_floor: assert property (@(posedge clk) disable iff (!rst_n)
        push && push_ev.on |-> push_ev.vel != '0);
    // R7: note-off carries velocity zero
    a_r7_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        push && !push_ev.on |-> push_ev.vel == '0);
    // R8: re-closing the upper contact while timing emits nothing
    a_r8_abandon: assert property (@(posedge clk) disable iff (!rst_n)
        walk_valid && cur_st == KS_TIMING && brk_closed |-> !push);
endmodule

// File: tb/kbd_vel_scan_tb.sv
module kbd_vel_scan_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSEL   = 12;
    localparam int NSENSE = 16;
    localparam int KPS    = NSENSE / 2;
    localparam int NKEYS  = NSEL * KPS;
    localparam int STEP   = 1;
    localparam int GAP    = 16;
    localparam int TBL_N  = 6;
    localparam int TBL_KEY [TBL_N] = '{7, 0, 13, 50, 95, 40};
    localparam int TBL_D   [TBL_N] = '{0, 1, 2, 10, 127, 130};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              scan_tick;
    logic [NSEL-1:0]   sel_n;
    logic [NSENSE-1:0] sense_n;
    logic              ev_valid;
    logic              ev_ready;
    logic [7:0]        ev_key;
    logic              ev_on;
    logic [6:0]        ev_vel;
    logic              ev_overflow;

    logic brk_cl [NKEYS];
    logic mk_cl  [NKEYS];

    int n_chk = 0;
    int n_bad = 0;
    int n_ev  = 0;
    int log_key [128];
    int log_on  [128];
    int log_vel [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_vel_scan #(
        .NUM_SEL    (NSEL),
        .NUM_SENSE  (NSENSE),
        .VEL_STEP   (STEP),
        .FIFO_DEPTH (4)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_tick   (scan_tick),
        .sel_n       (sel_n),
        .sense_n     (sense_n),
        .ev_valid    (ev_valid),
        .ev_ready    (ev_ready),
        .ev_key      (ev_key),
        .ev_on       (ev_on),
        .ev_vel      (ev_vel),
        .ev_overflow (ev_overflow)
    );

    // Contact model: only the column whose select is low pulls sense lines down.
    always_comb begin
        sense_n = '1;
        for (int c = 0; c < NSEL; c++) begin
            if (!sel_n[c]) begin
                for (int k = 0; k < KPS; k++) begin
                    if (brk_cl[c*KPS+k]) sense_n[2*k]   = 1'b0;
                    if (mk_cl[c*KPS+k])  sense_n[2*k+1] = 1'b0;
                end
            end
        end
    end

    // Event monitor: records each accepted event.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && ev_valid && ev_ready) begin
            if (n_ev < 128) begin
                log_key[n_ev] = int'(ev_key);
                log_on[n_ev]  = int'(ev_on);
                log_vel[n_ev] = int'(ev_vel);
            end
            n_ev++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) scan_tick = 1'b1;
        @(negedge clk) scan_tick = 1'b0;
        repeat (GAP - 2) @(negedge clk);
    endtask

    task automatic run_pass(input int n);
        repeat (n * NSEL) tick();
    endtask

    function automatic int exp_vel(input int d);
        int v;
        if (d <= 1) return 127;
        v = 127 - (d - 1) * STEP;
        return (v < 1) ? 1 : v;
    endfunction

    task automatic chk_last(input string req, input int key, input int on, input int vel);
        chk(log_key[n_ev-1] == key, {req, " key"}, log_key[n_ev-1], key);
        chk(log_on[n_ev-1]  == on,  {req, " on"},  log_on[n_ev-1],  on);
        chk(log_vel[n_ev-1] == vel, {req, " vel"}, log_vel[n_ev-1], vel);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        for (int i = 0; i < NKEYS; i++) begin
            brk_cl[i] = 1'b1;
            mk_cl[i]  = 1'b0;
        end
        rst_n     = 1'b0;
        scan_tick = 1'b0;
        ev_ready  = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk(sel_n == '1, "R1 sel idle", int'(sel_n), 4095);
        chk(ev_valid == 1'b0, "R1 no event", int'(ev_valid), 0);
        chk(ev_overflow == 1'b0, "R1 overflow low", int'(ev_overflow), 0);

        // R2: first tick drives column 0, then columns step and wrap
        tick();
        chk(sel_n == 12'hFFE, "R2 first column", int'(sel_n), 4094);
        for (int i = 0; i < NSEL; i++) begin
            tick();
            chk(sel_n == ~(12'h001 << ((i + 1) % NSEL)), "R2 column step",
                int'(sel_n), int'(~(12'h001 << ((i + 1) % NSEL)) & 12'hFFF));
        end
        chk(n_ev == 0, "R3 idle keys silent", n_ev, 0);

        // Vector table: press with lower contact d passes late, then release (R3 R4 R5 R6 R11 R7)
        for (int t = 0; t < TBL_N; t++) begin
            base = n_ev;
            brk_cl[TBL_KEY[t]] = 1'b0;
            if (TBL_D[t] == 0) mk_cl[TBL_KEY[t]] = 1'b1;
            run_pass(1);
            if (TBL_D[t] > 0) begin
                run_pass(TBL_D[t] - 1);
                mk_cl[TBL_KEY[t]] = 1'b1;
                run_pass(1);
            end
            chk(n_ev == base + 1, "R5 one note-on", n_ev - base, 1);
            chk_last("R5 R6 R11 note-on", TBL_KEY[t], 1, exp_vel(TBL_D[t]));
            mk_cl[TBL_KEY[t]]  = 1'b0;
            brk_cl[TBL_KEY[t]] = 1'b1;
            run_pass(1);
            chk(n_ev == base + 2, "R7 one note-off", n_ev - base, 2);
            chk_last("R7 note-off", TBL_KEY[t], 0, 0);
        end

        // R8: abandoned press emits nothing and the key returns to idle
        base = n_ev;
        brk_cl[20] = 1'b0;
        run_pass(3);
        brk_cl[20] = 1'b1;
        run_pass(1);
        chk(n_ev == base, "R8 no event", n_ev - base, 0);
        brk_cl[20] = 1'b0;
        run_pass(1);
        mk_cl[20] = 1'b1;
        run_pass(1);
        chk(n_ev == base + 1, "R8 R4 fresh press", n_ev - base, 1);
        chk_last("R8 R4 restart", 20, 1, 127);
        mk_cl[20]  = 1'b0;
        brk_cl[20] = 1'b1;
        run_pass(1);

        // R9 R10: five events into a four-deep queue with ready low
        base = n_ev;
        ev_ready = 1'b0;
        for (int k = 24; k < 29; k++) begin
            brk_cl[k] = 1'b0;
            mk_cl[k]  = 1'b1;
        end
        run_pass(1);
        chk(ev_overflow == 1'b1, "R10 overflow set", int'(ev_overflow), 1);
        chk(ev_valid == 1'b1 && ev_key == 8'd24, "R9 head order", int'(ev_key), 24);
        repeat (5) @(negedge clk);
        chk(ev_valid == 1'b1 && ev_key == 8'd24 && ev_vel == 7'd127, "R9 head held",
            int'(ev_key), 24);
        ev_ready = 1'b1;
        repeat (10) @(negedge clk);
        chk(n_ev == base + 4, "R10 newest dropped", n_ev - base, 4);
        chk_last("R9 R10 last kept", 27, 1, 127);
        for (int k = 24; k < 29; k++) begin
            brk_cl[k] = 1'b1;
            mk_cl[k]  = 1'b0;
        end
        run_pass(1);
        chk(n_ev == base + 9, "R7 five note-offs", n_ev - base, 9);
        chk(ev_overflow == 1'b1, "R10 overflow sticky", int'(ev_overflow), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule